// File: doc/BRIEF.md
# Multi-Stream Slot Allocation Table

This block keeps the slot map of a multi-stream link whose payload is carried in transfer units of 64 slots. Slot 0 of every unit is the header and slots 1 to 63 carry payload. The table has four entries. Each entry holds a stream source id and a slot count. The entries fill consecutive slots starting at slot 1, in entry order. A free-running slot position advances on each `slot_tick`, and the block presents the source id that owns the current slot.

Software loads a shadow copy of the table one entry at a time. It then issues an update command. Command 1 first raises a single-cycle allocation-change trigger and then swaps the table. Command 2 swaps the table without any trigger. The swap copies the shadow table into the active table at a transfer-unit boundary. The update field can be read back and clears to 0 by itself once the swap is done. After the swap, a keepout flag stays high for 16 transfer units. While the update field is nonzero or keepout is high, the block ignores further commands. An update whose total slot count would not fit in 63 payload slots is rejected and raises an error bit. Unused entries are loaded with source 0 and count 0.

Top module: `sat_alloc_table`

## Requirements
- R1: After synchronous reset, `slot_pos`, `slot_src`, `trig_req`, `upd_field`, `keepout` and `alloc_err` are all 0, and every active entry is source 0 with count 0.
- R2: Each cycle with `slot_tick` high advances `slot_pos` by one, wrapping from 63 to 0. While `slot_pos` is 0 (the header), `slot_src` is 0.
- R3: Active entry k owns the contiguous slots that follow the slots of entries 0..k-1, starting at slot 1. An entry with count 0 owns no slot. Payload slots past the last owned slot read source 0.
- R4: Shadow writes (`cfg_we` with `cfg_idx`, `cfg_src`, `cfg_cnt`) never change `slot_src` directly. A shadow write presented while `upd_field` is nonzero is discarded.
- R5: Command code 2 sets `upd_field` to 2 in the cycle after acceptance and raises no trigger. The shadow table becomes active from the next header slot (slot 0 following a tick at slot 63), and at that point `upd_field` returns to 0.
- R6: Command code 1 sets `upd_field` to 1 and raises `trig_req` for exactly one cycle, in the cycle after acceptance. The swap happens at the first unit boundary whose tick comes after the pulse cycle, and `upd_field` then returns to 0.
- R7: `keepout` rises with the swap and stays at 1 for exactly 16 × 64 slot ticks, which means it clears on the 16th boundary tick that follows the swap.
- R8: A command is ignored while `upd_field` is nonzero or `keepout` is 1. Codes 0 and 3 never start an update.
- R9: A code 1 or 2 command whose shadow counts sum to more than 63 is rejected. It sets `alloc_err`, leaves `upd_field` at 0 and leaves the active table unchanged. A sum of exactly 63 is accepted. An accepted command clears `alloc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Shadow entry write strobe |
| cfg_idx | input | 2 | Shadow entry index |
| cfg_src | input | 4 | Source id to write |
| cfg_cnt | input | 6 | Slot count to write |
| cmd_valid | input | 1 | Update command strobe |
| cmd_code | input | 2 | 0 none, 1 update with trigger, 2 update without trigger, 3 none |
| slot_tick | input | 1 | Advances the slot position |
| slot_pos | output | 6 | Current slot within the transfer unit (0 is the header) |
| slot_src | output | 4 | Source id owning the current slot in the active table |
| trig_req | output | 1 | Single-cycle allocation-change trigger request |
| upd_field | output | 2 | Pending update code, self-clearing |
| keepout | output | 1 | High for 16 transfer units after a swap |
| alloc_err | output | 1 | Last command rejected for slot overflow |

## Verification
The bench builds the block with its default parameters: four entries, 4-bit source ids, 64-slot units and a keepout of 16 headers. It ticks the slot counter every cycle, so one keepout window costs about a thousand cycles and several complete windows fit in a short run. With these values the bench can hit the exact 63-slot fill, with the last entry landing on slot 63. It can also hit the 64-slot overflow, a zero-count entry placed between used entries, and the exact length of the keepout window, all at the real unit size.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int DEF_ENTRIES      = 4;
    localparam int DEF_SRC_W        = 4;
    localparam int DEF_TU_SLOTS     = 64;
    localparam int DEF_KEEPOUT_HDRS = 16;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_TRIG   = 2'd1,
        UPD_SILENT = 2'd2,
        UPD_RSVD   = 2'd3
    } upd_code_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT    = 2'd1,
        ST_KEEPOUT = 2'd2
    } ctl_state_e;

    function automatic logic is_update(input logic [1:0] code);
        return (code == UPD_TRIG) || (code == UPD_SILENT);
    endfunction

endpackage

// File: rtl/sat_shadow.sv
module sat_shadow #(
    parameter int ENTRIES = 4,
    parameter int SRC_W   = 4,
    parameter int CNT_W   = 6,
    parameter int IDX_W   = 2,
    parameter int SUM_W   = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [SRC_W-1:0]           wr_src,
    input  logic [CNT_W-1:0]           wr_cnt,
    input  logic                       lock,
    output logic [ENTRIES*SRC_W-1:0]   sh_src,
    output logic [ENTRIES*CNT_W-1:0]   sh_cnt,
    output logic [SUM_W-1:0]           sh_total
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_src[e*SRC_W +: SRC_W] <= '0;
                sh_cnt[e*CNT_W +: CNT_W] <= '0;
            end else if (wr_en && !lock && (wr_idx == IDX_W'(e))) begin
                sh_src[e*SRC_W +: SRC_W] <= wr_src;
                sh_cnt[e*CNT_W +: CNT_W] <= wr_cnt;
            end
        end
    end

    always_comb begin
        sh_total = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            sh_total = sh_total + SUM_W'(sh_cnt[k*CNT_W +: CNT_W]);
        end
    end

endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
    import sat_pkg::*;
#(
    parameter int SUM_W        = 9,
    parameter int TU_SLOTS     = 64,
    parameter int KEEPOUT_HDRS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_code,
    input  logic [SUM_W-1:0] total,
    input  logic             boundary,
    output logic [1:0]       upd_field,
    output logic             trig_req,
    output logic             keepout,
    output logic             alloc_err,
    output logic             commit
);

    localparam int KO_W = $clog2(KEEPOUT_HDRS + 1);

    ctl_state_e      state;
    logic [1:0]      code_q;
    logic            trig_q;
    logic            err_q;
    logic [KO_W-1:0] ko_cnt;
    logic            accept;
    logic            over;

    assign accept = cmd_valid && (state == ST_IDLE) && is_update(cmd_code);
    assign over   = total > SUM_W'(TU_SLOTS - 1);
    assign commit = (state == ST_WAIT) && boundary && !trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            code_q <= UPD_NONE;
            trig_q <= 1'b0;
            err_q  <= 1'b0;
            ko_cnt <= '0;
        end else begin
            trig_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (over) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q  <= 1'b0;
                            code_q <= cmd_code;
                            trig_q <= (cmd_code == UPD_TRIG);
                            state  <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (commit) begin
                        code_q <= UPD_NONE;
                        ko_cnt <= '0;
                        state  <= ST_KEEPOUT;
                    end
                end
                ST_KEEPOUT: begin
                    if (boundary) begin
                        if (ko_cnt == KO_W'(KEEPOUT_HDRS - 1)) begin
                            state <= ST_IDLE;
                        end else begin
                            ko_cnt <= ko_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign upd_field = code_q;
    assign trig_req  = trig_q;
    assign keepout   = (state == ST_KEEPOUT);
    assign alloc_err = err_q;

endmodule

// File: rtl/sat_slot_map.sv
module sat_slot_map #(
    parameter int ENTRIES  = 4,
    parameter int SRC_W    = 4,
    parameter int CNT_W    = 6,
    parameter int POS_W    = 6,
    parameter int SUM_W    = 9,
    parameter int TU_SLOTS = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic                     commit,
    input  logic [ENTRIES*SRC_W-1:0] sh_src,
    input  logic [ENTRIES*CNT_W-1:0] sh_cnt,
    output logic [POS_W-1:0]         pos,
    output logic [SRC_W-1:0]         src,
    output logic                     boundary
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(TU_SLOTS - 1);

    logic [ENTRIES*SRC_W-1:0] act_src;
    logic [ENTRIES*CNT_W-1:0] act_cnt;

    assign boundary = tick && (pos == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (tick) begin
            pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_src <= '0;
            act_cnt <= '0;
        end else if (commit) begin
            act_src <= sh_src;
            act_cnt <= sh_cnt;
        end
    end

    always_comb begin
        logic [SUM_W-1:0] lo;
        logic [SUM_W-1:0] hi;
        logic [SUM_W-1:0] p;
        p   = SUM_W'(pos);
        lo  = SUM_W'(1);
        src = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            hi = lo + SUM_W'(act_cnt[k*CNT_W +: CNT_W]);
            if (p >= lo && p < hi) begin
                src = act_src[k*SRC_W +: SRC_W];
            end
            lo = hi;
        end
    end

endmodule

// File: rtl/sat_alloc_table.sv
module sat_alloc_table
    import sat_pkg::*;
#(
    parameter int ENTRIES      = DEF_ENTRIES,
    parameter int SRC_W        = DEF_SRC_W,
    parameter int TU_SLOTS     = DEF_TU_SLOTS,
    parameter int KEEPOUT_HDRS = DEF_KEEPOUT_HDRS,
    localparam int POS_W       = $clog2(TU_SLOTS),
    localparam int CNT_W       = POS_W,
    localparam int IDX_W       = $clog2(ENTRIES),
    localparam int SUM_W       = CNT_W + IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [CNT_W-1:0] cfg_cnt,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_code,
    input  logic             slot_tick,
    output logic [POS_W-1:0] slot_pos,
    output logic [SRC_W-1:0] slot_src,
    output logic             trig_req,
    output logic [1:0]       upd_field,
    output logic             keepout,
    output logic             alloc_err
);

    logic [ENTRIES*SRC_W-1:0] sh_src;
    logic [ENTRIES*CNT_W-1:0] sh_cnt;
    logic [SUM_W-1:0]         sh_total;
    logic                     boundary;
    logic                     commit;

    sat_shadow #(
        .ENTRIES(ENTRIES), .SRC_W(SRC_W), .CNT_W(CNT_W),
        .IDX_W(IDX_W), .SUM_W(SUM_W)
    ) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_src   (cfg_src),
        .wr_cnt   (cfg_cnt),
        .lock     (upd_field != 2'd0),
        .sh_src   (sh_src),
        .sh_cnt   (sh_cnt),
        .sh_total (sh_total)
    );

    sat_ctrl #(
        .SUM_W(SUM_W), .TU_SLOTS(TU_SLOTS), .KEEPOUT_HDRS(KEEPOUT_HDRS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .total     (sh_total),
        .boundary  (boundary),
        .upd_field (upd_field),
        .trig_req  (trig_req),
        .keepout   (keepout),
        .alloc_err (alloc_err),
        .commit    (commit)
    );

    sat_slot_map #(
        .ENTRIES(ENTRIES), .SRC_W(SRC_W), .CNT_W(CNT_W),
        .POS_W(POS_W), .SUM_W(SUM_W), .TU_SLOTS(TU_SLOTS)
    ) u_map (
        .clk      (clk),
        .rst      (rst),
        .tick     (slot_tick),
        .commit   (commit),
        .sh_src   (sh_src),
        .sh_cnt   (sh_cnt),
        .pos      (slot_pos),
        .src      (slot_src),
        .boundary (boundary)
    );

endmodule

// File: rtl/sat_alloc_chk.sv
module sat_alloc_chk #(
    parameter int POS_W    = 6,
    parameter int SRC_W    = 4,
    parameter int TU_SLOTS = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             slot_tick,
    input logic [POS_W-1:0] slot_pos,
    input logic [SRC_W-1:0] slot_src,
    input logic             trig_req,
    input logic [1:0]       upd_field,
    input logic             keepout
);

    // R2
    pos_step_chk: assert property (@(posedge clk) disable iff (rst)
        slot_tick |=> slot_pos == (($past(slot_pos) == POS_W'(TU_SLOTS - 1)) ? '0 : $past(slot_pos) + 1'b1));

    // R2
    header_src_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_pos == '0) |-> (slot_src == '0));

    // R6
    trig_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig_req |=> !trig_req);

    // R6
    trig_code_chk: assert property (@(posedge clk) disable iff (rst)
        trig_req |-> (upd_field == 2'd1));

    // R5
    swap_at_header_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_field != 2'd0) ##1 (upd_field == 2'd0) |-> (slot_pos == '0 && keepout));

    // R7
    keepout_idle_chk: assert property (@(posedge clk) disable iff (rst)
        keepout |-> (upd_field == 2'd0));

    // R8
    keepout_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (keepout && cmd_valid) |=> (upd_field == 2'd0));

endmodule

bind sat_alloc_table sat_alloc_chk #(
    .POS_W(POS_W), .SRC_W(SRC_W), .TU_SLOTS(TU_SLOTS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .slot_tick (slot_tick),
    .slot_pos  (slot_pos),
    .slot_src  (slot_src),
    .trig_req  (trig_req),
    .upd_field (upd_field),
    .keepout   (keepout)
);

// File: tb/tb_sat_alloc_table.sv
module tb_sat_alloc_table;

    localparam int TU  = 64;
    localparam int KOH = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [1:0] cfg_idx;
    logic [3:0] cfg_src;
    logic [5:0] cfg_cnt;
    logic       cmd_valid;
    logic [1:0] cmd_code;
    logic       slot_tick;
    logic [5:0] slot_pos;
    logic [3:0] slot_src;
    logic       trig_req;
    logic [1:0] upd_field;
    logic       keepout;
    logic       alloc_err;

    int total_n = 0;
    int bad_n   = 0;
    bit done    = 0;
    int ko_cycles = 0;
    bit trig_seen;

    int m_src [4];
    int m_cnt [4];

    int    q_pos [$];
    int    q_src [$];
    string q_req [$];

    always #10 clk = ~clk;

    sat_alloc_table dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_src(cfg_src), .cfg_cnt(cfg_cnt), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .slot_tick(slot_tick), .slot_pos(slot_pos),
        .slot_src(slot_src), .trig_req(trig_req), .upd_field(upd_field),
        .keepout(keepout), .alloc_err(alloc_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total_n++;
        if (act != exp) begin
            bad_n++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_src(input int p);
        int lo;
        if (p == 0) return 0;
        lo = 1;
        for (int k = 0; k < 4; k++) begin
            if (p >= lo && p < lo + m_cnt[k]) return m_src[k];
            lo += m_cnt[k];
        end
        return 0;
    endfunction

    // monitor: pops scoreboard items, away from the clock edges
    always begin
        @(posedge clk);
        #5;
        if (!rst && keepout) ko_cycles++;
        if (q_pos.size() > 0 && int'(slot_pos) == q_pos[0]) begin
            chk(q_req[0], int'(slot_src), q_src[0]);
            void'(q_pos.pop_front());
            void'(q_src.pop_front());
            void'(q_req.pop_front());
        end
    end

    task automatic expect_tu(input string req);
        for (int p = 0; p < TU; p++) begin
            q_pos.push_back(p);
            q_src.push_back(exp_src(p));
            q_req.push_back(req);
        end
        while (q_pos.size() != 0) @(negedge clk);
    endtask

    task automatic wr_entry(input int idx, input int src, input int cnt);
        @(negedge clk);
        cfg_we  = 1'b1;
        cfg_idx = 2'(idx);
        cfg_src = 4'(src);
        cfg_cnt = 6'(cnt);
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    task automatic send_cmd(input int code);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = 2'(code);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 2'd0;
    endtask

    task automatic wait_pos(input int p);
        @(negedge clk);
        while (int'(slot_pos) != p) @(negedge clk);
    endtask

    task automatic wait_swap();
        trig_seen = 0;
        while (upd_field != 2'd0) begin
            @(negedge clk);
            if (trig_req) trig_seen = 1;
        end
    endtask

    task automatic set_model(input int s0, input int c0, input int s1, input int c1,
                             input int s2, input int c2, input int s3, input int c3);
        m_src[0] = s0; m_cnt[0] = c0; m_src[1] = s1; m_cnt[1] = c1;
        m_src[2] = s2; m_cnt[2] = c2; m_src[3] = s3; m_cnt[3] = c3;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad_n++;
            total_n++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total_n, bad_n);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_src = '0; cfg_cnt = '0;
        cmd_valid = 1'b0; cmd_code = '0; slot_tick = 1'b0;
        set_model(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pos", int'(slot_pos), 0);
        chk("R1 src", int'(slot_src), 0);
        chk("R1 trig", int'(trig_req), 0);
        chk("R1 upd", int'(upd_field), 0);
        chk("R1 keepout", int'(keepout), 0);
        chk("R1 err", int'(alloc_err), 0);
        slot_tick = 1'b1;
        @(negedge clk);
        chk("R2 pos advance", int'(slot_pos), 1);
        expect_tu("R2 empty table");

        // R4: shadow writes leave the active table alone
        wr_entry(0, 3, 10);
        wr_entry(1, 5, 20);
        wr_entry(2, 0, 0);
        wr_entry(3, 7, 5);
        expect_tu("R4 shadow not active");

        // R5: silent update
        wait_pos(5);
        send_cmd(2);
        chk("R5 upd code", int'(upd_field), 2);
        chk("R5 no trig", int'(trig_req), 0);
        ko_cycles = 0;
        wait_swap();
        chk("R5 no trig while pending", int'(trig_seen), 0);
        chk("R5 swap at header", int'(slot_pos), 0);
        chk("R7 keepout set", int'(keepout), 1);
        set_model(3, 10, 5, 20, 0, 0, 7, 5);
        expect_tu("R3 zero-count entry skipped");

        // R8: command ignored during keepout
        send_cmd(1);
        chk("R8 keepout ignore upd", int'(upd_field), 0);
        chk("R8 keepout ignore trig", int'(trig_req), 0);
        wr_entry(0, 9, 30);
        wr_entry(1, 4, 33);
        wr_entry(2, 0, 0);
        wr_entry(3, 0, 0);
        while (keepout) @(negedge clk);
        chk("R7 keepout length", ko_cycles, KOH * TU);

        // R6: update with trigger, total exactly 63
        wait_pos(5);
        send_cmd(1);
        chk("R6 trig pulse", int'(trig_req), 1);
        chk("R6 upd code", int'(upd_field), 1);
        @(negedge clk);
        chk("R6 trig single", int'(trig_req), 0);
        wr_entry(0, 15, 1);
        wait_swap();
        chk("R6 swap at header", int'(slot_pos), 0);
        chk("R6 upd cleared", int'(upd_field), 0);
        set_model(9, 30, 4, 33, 0, 0, 0, 0);
        expect_tu("R4 write locked / R9 full 63");

        // R8: codes 3 and 0 do nothing
        while (keepout) @(negedge clk);
        send_cmd(3);
        chk("R8 code3 upd", int'(upd_field), 0);
        chk("R8 code3 trig", int'(trig_req), 0);
        send_cmd(0);
        chk("R8 code0 upd", int'(upd_field), 0);

        // R9: overflow rejected
        wr_entry(2, 6, 1);
        send_cmd(2);
        chk("R9 err set", int'(alloc_err), 1);
        chk("R9 upd stays 0", int'(upd_field), 0);
        expect_tu("R9 table unchanged");
        chk("R9 no keepout", int'(keepout), 0);

        // R9: valid update clears the error
        wr_entry(1, 4, 32);
        wait_pos(5);
        send_cmd(2);
        chk("R9 err cleared", int'(alloc_err), 0);
        chk("R9 accepted", int'(upd_field), 2);
        wait_swap();
        set_model(9, 30, 4, 32, 6, 1, 0, 0);
        expect_tu("R3 last slot");

        done = 1;
        $display("test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    end

endmodule